// File: doc/BRIEF.md
# Pixel Matrix Configuration Sequencer

This block drives the four-wire serial configuration port of a pixel sensor: a global shift clock, a pixel shift clock, one serial data line and a load strobe. Whichever clock toggles decides which on-chip shift chain takes the data. After a single start pulse the block first shifts the global bias register and latches it. It then rewrites the full pixel chain sixty times, so that every pixel of the 12 x 20 unit-cell matrix receives its own 4-bit threshold trim.

A trim value can reach only one column per chain write. Its column is picked by a single load-enable bit in the column part of the chain, and each write reaches two of the six pixels of a unit cell. The pass therefore walks the columns in ascending order and, inside each column, the three pixel pairs. The trims come from an internal RAM that is filled beforehand through a plain write port. The global register is built from parameters whose defaults are the working-point DAC settings. The serial clock runs at the system clock divided by a parameter.

Top module: `pix_cfg_seq`

## Requirements
- R1: During reset, and while idle with no start, every output (cfg_gclk, cfg_pclk, cfg_sdata, cfg_load, busy, done) is 0.
- R2: Global-chain bits are clocked only by cfg_gclk, and only during the global write. Pixel-chain bits are clocked only by cfg_pclk. The two clocks are never high together.
- R3: The global write is 120 bits, shifted MSB first from the vector {dac18, ..., dac0, sw[5:0]} with 6-bit DAC fields. The defaults are dac0 (feedback) = 1, dac1 (threshold step) = 20, dac2..dac4 (output amplitudes) = 60, all other DACs 0 and all switches 0.
- R4: Each pixel write is 352 bits. It holds the 8-bit column segments for columns 19 down to 0, then the 16-bit row segments for rows 11 down to 0, each segment MSB first. A row segment is {right trim[3:0], left trim[3:0], 8'h3C}.
- R5: In a pixel write, bit 0 of the column segment is the load-enable bit. It is 1 only in the target column's segment. Every other column-segment bit is 0.
- R6: Each write is followed by one cfg_load pulse of exactly one serial period (DIV system cycles), with both serial clocks low. A pass makes 61 loads: the global write first, then 60 pixel writes.
- R7: Pixel write w (0..59) targets column w/3 and pixel pair w%3. Row r of that write takes its trims from RAM address w*12 + r, where data[7:4] is the right trim and data[3:0] the left trim.
- R8: A start pulse while busy is ignored. The pass neither restarts nor adds loads.
- R9: busy rises in the cycle after start and stays high until the final load ends. done is a one-cycle pulse in the cycle where busy falls.
- R10: A serial bit lasts DIV system cycles, with the active clock low for the first DIV/2 and high for the rest. cfg_sdata changes only while both clocks are low.
- R11: When trim_we is high at a clock edge, trim_data is written at trim_addr. The contents persist, and a later pass uses the rewritten values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration pass (one-cycle pulse) |
| trim_we | input | 1 | Trim RAM write enable |
| trim_addr | input | 10 | Trim RAM write address (write*12 + row) |
| trim_data | input | 8 | {right trim, left trim} |
| cfg_gclk | output | 1 | Global chain shift clock |
| cfg_pclk | output | 1 | Pixel chain shift clock |
| cfg_sdata | output | 1 | Serial configuration data |
| cfg_load | output | 1 | Latch strobe for the shifted chain |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The assertions check the cycle-level rules on every cycle. They cover mutual exclusion of the two serial clocks and their confinement to the global and pixel phases, silent clocks while the load strobe is high, the exact load width, data held steady while a clock is high, the bounded serial phase, and a single-cycle done that coincides with busy falling. The bench scenarios are the only place where the contents are checked. They decode the stream bit by bit at every rising serial clock and compare each of the 61 latched images against a model built from the trim table. This shows the global defaults, the segment order, the single load-enable per column, the column and pair order, the RAM mapping after a rewrite, and that a mid-pass start leaves the sequence intact.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GSHIFT,
    ST_GLOAD,
    ST_PSHIFT,
    ST_PLOAD
  } seq_st_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pcs_tick.sv
module pcs_tick #(
  parameter int unsigned DIV = 4,
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic wrap,
  output logic hi_n
);

  localparam int unsigned HALF = DIV / 2;

  logic [PW-1:0] ph;
  logic [PW-1:0] ph_n;

  assign wrap = run && (ph == PW'(DIV - 1));
  assign ph_n = (!run || wrap) ? '0 : ph + 1'b1;
  assign hi_n = run && (ph_n >= PW'(HALF));

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph_n;
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    ph <= PW'(DIV - 1)); // R10

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> ph == '0); // R10

endmodule

// File: rtl/pcs_trim_ram.sv
module pcs_trim_ram #(
  parameter int unsigned DEPTH = 720,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pcs_bitsel.sv
module pcs_bitsel #(
  parameter int unsigned DAC_W    = 6,
  parameter int unsigned N_GDAC   = 19,
  parameter int unsigned N_SW     = 6,
  parameter int unsigned FB_DAC   = 1,
  parameter int unsigned STEP_DAC = 20,
  parameter int unsigned AMP_DAC  = 60,
  parameter logic [N_SW-1:0] SW_INIT = '0,
  parameter int unsigned ROW_SEG  = 16,
  parameter int unsigned TRIM_W   = 4,
  parameter logic [ROW_SEG-2*TRIM_W-1:0] ROW_CTRL = 'h3C,
  parameter int unsigned LDEN_POS = 0,
  parameter int unsigned BW       = 7,
  parameter int unsigned SGW      = 5,
  parameter int unsigned CLW      = 5
) (
  input  logic               glb_sel,
  input  logic               pix_sel,
  input  logic               rows,
  input  logic [BW-1:0]      bitp,
  input  logic [SGW-1:0]     seg,
  input  logic [CLW-1:0]     col,
  input  logic [2*TRIM_W-1:0] trim,
  output logic               val
);

  localparam int unsigned GLB_BITS = N_GDAC * DAC_W + N_SW;
  localparam int unsigned RIW      = $clog2(ROW_SEG);
  localparam int unsigned GIW      = $clog2(GLB_BITS);

  function automatic logic [GLB_BITS-1:0] build_glb();
    logic [GLB_BITS-1:0] v;
    v = '0;
    v[N_SW-1:0] = SW_INIT;
    v[N_SW +: DAC_W] = DAC_W'(FB_DAC);
    v[N_SW + DAC_W +: DAC_W] = DAC_W'(STEP_DAC);
    for (int k = 2; k < 5; k++) v[N_SW + k * DAC_W +: DAC_W] = DAC_W'(AMP_DAC);
    return v;
  endfunction

  localparam logic [GLB_BITS-1:0] GLB_VEC = build_glb();

  logic [ROW_SEG-1:0] row_word;
  logic               glb_bit;
  logic               col_bit;
  logic               row_bit;

  assign row_word = {trim, ROW_CTRL};
  assign row_bit  = row_word[bitp[RIW-1:0]];
  assign glb_bit  = GLB_VEC[bitp[GIW-1:0]];
  assign col_bit  = (bitp == BW'(LDEN_POS)) && (seg == SGW'(col));

  always_comb begin
    if (glb_sel)      val = glb_bit;
    else if (pix_sel) val = rows ? row_bit : col_bit;
    else              val = 1'b0;
  end

endmodule

// File: rtl/pix_cfg_seq.sv
module pix_cfg_seq
  import pcs_pkg::*;
#(
  parameter int unsigned DIV      = 4,
  parameter int unsigned DAC_W    = 6,
  parameter int unsigned N_GDAC   = 19,
  parameter int unsigned N_SW     = 6,
  parameter int unsigned FB_DAC   = 1,
  parameter int unsigned STEP_DAC = 20,
  parameter int unsigned AMP_DAC  = 60,
  parameter logic [N_SW-1:0] SW_INIT = '0,
  parameter int unsigned N_ROWS   = 12,
  parameter int unsigned N_COLS   = 20,
  parameter int unsigned PAIRS    = 3,
  parameter int unsigned ROW_SEG  = 16,
  parameter int unsigned COL_SEG  = 8,
  parameter int unsigned TRIM_W   = 4,
  parameter int unsigned LDEN_POS = 0,
  parameter logic [ROW_SEG-2*TRIM_W-1:0] ROW_CTRL = 'h3C,
  localparam int unsigned DEPTH   = N_COLS * PAIRS * N_ROWS,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned TW      = 2 * TRIM_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          trim_we,
  input  logic [AW-1:0] trim_addr,
  input  logic [TW-1:0] trim_data,
  output logic          cfg_gclk,
  output logic          cfg_pclk,
  output logic          cfg_sdata,
  output logic          cfg_load,
  output logic          busy,
  output logic          done
);

  localparam int unsigned GLB_BITS = N_GDAC * DAC_W + N_SW;
  localparam int unsigned BW  = $clog2(max3(GLB_BITS, ROW_SEG, COL_SEG));
  localparam int unsigned SGW = $clog2((N_COLS > N_ROWS) ? N_COLS : N_ROWS);
  localparam int unsigned CLW = (N_COLS > 1) ? $clog2(N_COLS) : 1;
  localparam int unsigned PRW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int unsigned LCW = $clog2(DIV + 1) + 1;

  seq_st_t        st_q, st_n;
  logic [BW-1:0]  bit_q, bit_n, a_bit;
  logic [SGW-1:0] seg_q, seg_n, a_seg;
  logic           rows_q, rows_n, a_rows, a_last;
  logic [CLW-1:0] col_q, col_n;
  logic [PRW-1:0] pair_q, pair_n;
  logic [AW-1:0]  base_q, base_n;
  logic           done_n, last_wr, upd;
  logic           wrap, hi_n, run;
  logic [AW-1:0]  ram_raddr;
  logic [TW-1:0]  ram_q;
  logic           bit_val;

  assign run = (st_q != ST_IDLE);

  pcs_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .wrap (wrap),
    .hi_n (hi_n)
  );

  assign ram_raddr = base_q + AW'(a_seg);

  pcs_trim_ram #(.DEPTH(DEPTH), .DW(TW)) u_ram (
    .clk   (clk),
    .we    (trim_we),
    .waddr (trim_addr),
    .wdata (trim_data),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  pcs_bitsel #(
    .DAC_W(DAC_W), .N_GDAC(N_GDAC), .N_SW(N_SW), .FB_DAC(FB_DAC),
    .STEP_DAC(STEP_DAC), .AMP_DAC(AMP_DAC), .SW_INIT(SW_INIT),
    .ROW_SEG(ROW_SEG), .TRIM_W(TRIM_W), .ROW_CTRL(ROW_CTRL),
    .LDEN_POS(LDEN_POS), .BW(BW), .SGW(SGW), .CLW(CLW)
  ) u_bitsel (
    .glb_sel (st_n == ST_GSHIFT),
    .pix_sel (st_n == ST_PSHIFT),
    .rows    (rows_n),
    .bitp    (bit_n),
    .seg     (seg_n),
    .col     (col_n),
    .trim    (ram_q),
    .val     (bit_val)
  );

  // Cursor advance: next bit position within the current chain.
  always_comb begin
    a_last = 1'b0;
    a_bit  = bit_q - 1'b1;
    a_seg  = seg_q;
    a_rows = rows_q;
    if (bit_q == '0) begin
      if (st_q == ST_GSHIFT) begin
        a_last = 1'b1;
      end else if (seg_q != '0) begin
        a_seg = seg_q - 1'b1;
        a_bit = rows_q ? BW'(ROW_SEG - 1) : BW'(COL_SEG - 1);
      end else if (!rows_q) begin
        a_rows = 1'b1;
        a_seg  = SGW'(N_ROWS - 1);
        a_bit  = BW'(ROW_SEG - 1);
      end else begin
        a_last = 1'b1;
      end
    end
  end

  assign last_wr = (col_q == CLW'(N_COLS - 1)) && (pair_q == PRW'(PAIRS - 1));
  assign upd     = wrap || ((st_q == ST_IDLE) && start);

  always_comb begin
    st_n   = st_q;
    bit_n  = bit_q;
    seg_n  = seg_q;
    rows_n = rows_q;
    col_n  = col_q;
    pair_n = pair_q;
    base_n = base_q;
    done_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_GSHIFT;
          bit_n  = BW'(GLB_BITS - 1);
          col_n  = '0;
          pair_n = '0;
          base_n = '0;
        end
      end
      ST_GSHIFT: begin
        if (wrap) begin
          if (a_last) st_n = ST_GLOAD;
          else        bit_n = a_bit;
        end
      end
      ST_GLOAD: begin
        if (wrap) begin
          st_n   = ST_PSHIFT;
          rows_n = 1'b0;
          seg_n  = SGW'(N_COLS - 1);
          bit_n  = BW'(COL_SEG - 1);
        end
      end
      ST_PSHIFT: begin
        if (wrap) begin
          if (a_last) begin
            st_n = ST_PLOAD;
          end else begin
            bit_n  = a_bit;
            seg_n  = a_seg;
            rows_n = a_rows;
          end
        end
      end
      ST_PLOAD: begin
        if (wrap) begin
          if (last_wr) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            st_n   = ST_PSHIFT;
            rows_n = 1'b0;
            seg_n  = SGW'(N_COLS - 1);
            bit_n  = BW'(COL_SEG - 1);
            base_n = base_q + AW'(N_ROWS);
            if (pair_q == PRW'(PAIRS - 1)) begin
              pair_n = '0;
              col_n  = col_q + 1'b1;
            end else begin
              pair_n = pair_q + 1'b1;
            end
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      seg_q     <= '0;
      rows_q    <= 1'b0;
      col_q     <= '0;
      pair_q    <= '0;
      base_q    <= '0;
      cfg_gclk  <= 1'b0;
      cfg_pclk  <= 1'b0;
      cfg_sdata <= 1'b0;
      cfg_load  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      st_q     <= st_n;
      bit_q    <= bit_n;
      seg_q    <= seg_n;
      rows_q   <= rows_n;
      col_q    <= col_n;
      pair_q   <= pair_n;
      base_q   <= base_n;
      cfg_gclk <= (st_n == ST_GSHIFT) && hi_n;
      cfg_pclk <= (st_n == ST_PSHIFT) && hi_n;
      cfg_load <= (st_n == ST_GLOAD) || (st_n == ST_PLOAD);
      busy     <= (st_n != ST_IDLE);
      done     <= done_n;
      if (upd) cfg_sdata <= bit_val;
    end
  end

  // Load-width counter used only by the assertion below.
  logic [LCW-1:0] ld_cnt;
  always_ff @(posedge clk) begin
    if (rst)           ld_cnt <= '0;
    else if (cfg_load) ld_cnt <= ld_cnt + 1'b1;
    else               ld_cnt <= '0;
  end

  AST_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !(cfg_gclk && cfg_pclk)); // R2

  AST_GCLK_IN_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    cfg_gclk |-> st_q == ST_GSHIFT); // R2

  AST_PCLK_IN_PIXEL: assert property (@(posedge clk) disable iff (rst)
    cfg_pclk |-> st_q == ST_PSHIFT); // R2

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> !cfg_gclk && !cfg_pclk && busy); // R6

  AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_load) |-> ld_cnt == LCW'(DIV)); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_gclk || cfg_pclk) |-> $stable(cfg_sdata)); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && st_q != ST_IDLE && start && !wrap) |=> $stable(st_q)); // R8

endmodule

// File: tb/pix_cfg_seq_test.sv
module pix_cfg_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int N_ROWS     = 12;
  localparam int N_COLS     = 20;
  localparam int PAIRS      = 3;
  localparam int COL_SEG    = 8;
  localparam int ROW_SEG    = 16;
  localparam int GBITS      = 120;
  localparam int COLB       = N_COLS * COL_SEG;
  localparam int PBITS      = COLB + N_ROWS * ROW_SEG;
  localparam int DEPTH      = N_COLS * PAIRS * N_ROWS;
  localparam int NLOADS     = 1 + N_COLS * PAIRS;

  logic clk = 1'b0;
  logic rst, start, trim_we;
  logic [9:0] trim_addr;
  logic [7:0] trim_data;
  logic cfg_gclk, cfg_pclk, cfg_sdata, cfg_load, busy, done;

  pix_cfg_seq #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .start(start), .trim_we(trim_we),
    .trim_addr(trim_addr), .trim_data(trim_data),
    .cfg_gclk(cfg_gclk), .cfg_pclk(cfg_pclk), .cfg_sdata(cfg_sdata),
    .cfg_load(cfg_load), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int run_no = 0;
  logic [7:0] tr [DEPTH];
  logic cap [384];
  int nbits, gr, pr, frames, hicnt, ldcnt, wid_err, hold_err;
  logic prev_g = 0, prev_p = 0, prev_l = 0, prev_b = 0, hold_v = 0;
  bit mon_en = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit glb_bit(input int i);
    int pos, k, b, v;
    pos = GBITS - 1 - i;
    if (pos < 6) return 1'b0;
    k = (pos - 6) / 6;
    b = (pos - 6) % 6;
    v = (k == 0) ? 1 : (k == 1) ? 20 : (k <= 4) ? 60 : 0;
    return v[b];
  endfunction

  function automatic bit pix_bit(input int w, input int i);
    int col, seg, bp, p, row;
    logic [15:0] word;
    col = w / PAIRS;
    if (i < COLB) begin
      seg = N_COLS - 1 - i / COL_SEG;
      bp  = COL_SEG - 1 - i % COL_SEG;
      return (bp == 0) && (seg == col);
    end
    p    = i - COLB;
    row  = N_ROWS - 1 - p / ROW_SEG;
    bp   = ROW_SEG - 1 - p % ROW_SEG;
    word = {tr[w * N_ROWS + row], 8'h3C};
    return word[bp];
  endfunction

  task automatic frame_check();
    int len, mism, first, ones;
    bit e, a;
    if (frames >= NLOADS) begin
      chk(0, "R8", "extra load in pass", frames + 1, NLOADS);
      return;
    end
    len = (frames == 0) ? GBITS : PBITS;
    chk(nbits == len, (frames == 0) ? "R3" : "R4", "bits in write", nbits, len);
    if (frames == 0) chk(gr == GBITS && pr == 0, "R2", "gclk rises in global write", gr, GBITS);
    else             chk(pr == PBITS && gr == 0, "R2", "pclk rises in pixel write", pr, PBITS);
    mism = 0; first = -1; ones = 0;
    for (int i = 0; i < len && i < nbits; i++) begin
      e = (frames == 0) ? glb_bit(i) : pix_bit(frames - 1, i);
      a = cap[i];
      if (a !== e) begin mism++; if (first < 0) first = i; end
      if (frames != 0 && i < COLB && a === 1'b1) ones++;
    end
    if (frames == 0) chk(mism == 0, "R3", "global image mismatches", mism, 0);
    else chk(mism == 0, (run_no == 2) ? "R4 R7 R11" : "R4 R7", "pixel image mismatches",
             mism, 0);
    if (mism != 0) $display("  frame %0d first bad bit %0d", frames, first);
    if (frames != 0) chk(ones == 1, "R5", "load-enable ones in column part", ones, 1);
    chk(wid_err == 0 && hold_err == 0, "R10", "clock width / data hold faults",
        wid_err + hold_err, 0);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (busy && !prev_b) frames = 0;
      if (cfg_gclk && !prev_g) begin
        gr++; if (nbits < 384) cap[nbits] = cfg_sdata; nbits++; hold_v = cfg_sdata;
      end
      if (cfg_pclk && !prev_p) begin
        pr++; if (nbits < 384) cap[nbits] = cfg_sdata; nbits++; hold_v = cfg_sdata;
      end
      if (cfg_gclk || cfg_pclk) begin
        hicnt++;
        if (cfg_sdata !== hold_v) hold_err++;
      end else if (hicnt != 0) begin
        if (hicnt != DIV / 2) wid_err++;
        hicnt = 0;
      end
      if (cfg_load && !prev_l) begin
        if (cfg_gclk || cfg_pclk) wid_err++;
        frame_check();
        frames++; nbits = 0; gr = 0; pr = 0; wid_err = 0; hold_err = 0;
      end
      if (cfg_load) ldcnt++;
      else if (prev_l) begin
        chk(ldcnt == DIV, "R6", "load pulse width", ldcnt, DIV);
        ldcnt = 0;
      end
      if (done) begin
        chk(!busy, "R9", "busy at done", busy, 0);
        chk(frames == NLOADS, "R6", "loads per pass", frames, NLOADS);
      end
    end
    prev_g = cfg_gclk; prev_p = cfg_pclk; prev_l = cfg_load; prev_b = busy;
  end

  task automatic write_trims();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      trim_we = 1'b1; trim_addr = 10'(a); trim_data = tr[a];
    end
    @(negedge clk);
    trim_we = 1'b0;
  endtask

  task automatic do_pass(input bit poke);
    int n;
    run_no++;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (poke) begin
      repeat (30000) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R8", "busy after start during pass", busy, 1);
    end
    n = 0;
    while (!done) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
    chk({cfg_gclk, cfg_pclk, cfg_load, busy} == 4'b0, "R1", "outputs idle after pass",
        {cfg_gclk, cfg_pclk, cfg_load, busy}, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; start = 1'b0; trim_we = 1'b0; trim_addr = '0; trim_data = '0;
    repeat (4) @(negedge clk);
    chk({cfg_gclk, cfg_pclk, cfg_sdata, cfg_load, busy, done} == 6'b0, "R1",
        "outputs in reset", {cfg_gclk, cfg_pclk, cfg_sdata, cfg_load, busy, done}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk({cfg_gclk, cfg_pclk, cfg_sdata, cfg_load, busy, done} == 6'b0, "R1",
        "outputs idle without start", {cfg_gclk, cfg_pclk, cfg_sdata, cfg_load, busy, done}, 0);

    // Pass 1: random trims, with a start pulse injected mid-pass (R8).
    for (int a = 0; a < DEPTH; a++) tr[a] = 8'($urandom);
    write_trims();
    mon_en = 1'b1;
    do_pass(1'b1);

    // Pass 2: directed corner pattern after rewriting the RAM (R11, R7).
    for (int a = 0; a < DEPTH; a++) tr[a] = (a % 2 == 1) ? 8'hF0 : 8'h0F;
    tr[0] = 8'hFF; tr[DEPTH-1] = 8'h81; tr[N_ROWS-1] = 8'h00;
    write_trims();
    do_pass(1'b0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule